// File: doc/BRIEF.md
# Four-channel DAC write sequencer with shared load strobe

This block pushes four 16-bit samples into an external four-channel DAC through a serial link that only writes. A single start strobe captures all four samples. The block then sends one 24-bit command frame per channel, in channel order 0 to 3. Each frame is bracketed by an active-low frame-select line. After the fourth frame and a settling delay, it drives one active-low load strobe that is shared by all channels, so every DAC output changes at the same moment.

The converter accepts a new frame only after an internal register-transfer interval. That interval is longer than a fast shift, so frame starts are held apart by a minimum start-to-start time. The frame-select line also stays high for a minimum time between frames. All timing minima are given as parameters in nanoseconds together with the system clock frequency. They are converted to clock cycles by rounding up. The serial clock half-period is set at run time by the divider input.

Top module: `quad_dac_loader`

## Requirements
- R1: After reset, `sync_n_o`, `sclk_o` and `ldac_n_o` are high, and `busy_o` and `done_o` are low.
- R2: One update sends exactly four frames, for channels 0, 1, 2, 3 in that order. Each frame is 24 bits, MSB first. Bits 23:20 hold command 4'b0001 (write input register, no output update). Bits 19:16 hold a one-hot channel select: bit 16 for channel 0 up to bit 19 for channel 3. Bits 15:0 hold the sample.
- R3: `sclk_o` is high whenever `sync_n_o` is high. Each bit starts with a high half and then a low half, each lasting D cycles, where D = `div_i` and a value of 0 counts as 1. `sdin_o` holds steady for the whole low half, so it is stable at the falling edge. `sync_n_o` stays low for exactly 48·D cycles per frame.
- R4: Consecutive frame starts (falling edges of `sync_n_o`) lie max(FRAME_CYC, 48·D + SYNCHI_CYC) cycles apart, where FRAME_CYC = ceil(T_FRAME_NS·CLK_MHZ/1000).
- R5: Between frames, `sync_n_o` stays high for at least SYNCHI_CYC cycles.
- R6: `ldac_n_o` falls exactly once per update, only after all four frames. It falls exactly LDLY_CYC cycles after the last rise of `sync_n_o`.
- R7: `ldac_n_o` stays low for exactly LDACW_CYC cycles.
- R8: `done_o` pulses high for one cycle in the cycle where `ldac_n_o` returns high, and `busy_o` falls at that point. `busy_o` is high from the cycle after start until then.
- R9: A start strobe that arrives while `busy_o` is high is ignored. The samples are captured at start, so later changes on `samples_i` do not alter an update that is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an update |
| samples_i | input | 4x16 | Channel samples; element n is channel n |
| div_i | input | DIV_W | Serial clock half-period in system cycles (0 acts as 1) |
| sclk_o | output | 1 | Serial clock, idles high |
| sdin_o | output | 1 | Serial data, changes on the rising edge of sclk |
| sync_n_o | output | 1 | Active-low frame select |
| ldac_n_o | output | 1 | Active-low shared load strobe |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench keeps the default timing: a 100 MHz clock, 830 ns spacing, 20 ns minimum high time on the frame-select line, an 800 ns load delay and a 20 ns strobe. These give 83, 2, 80 and 2 cycles. Dividers 1 and 0 make each shift 48 cycles, so the 83-cycle spacing sets the gap. Dividers 2 and 3 make the shift plus the 2-cycle high time set the gap instead. Both branches of R4 are therefore exercised. The 2-cycle strobe and high-time values make an off-by-one in either rounding or counting show up directly in the measured widths.

// File: rtl/qdl_pkg.sv
package qdl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEND,
        S_GAP,
        S_LDLY,
        S_LPULSE
    } seq_state_e;

    // command nibble: write to an input register without updating the output
    localparam logic [3:0] CMD_WR_INPUT = 4'b0001;

    function automatic logic [23:0] make_frame(input logic [1:0] ch, input logic [15:0] val);
        logic [3:0] sel;
        sel = 4'b0001 << ch;
        return {CMD_WR_INPUT, sel, val};
    endfunction

    // ns -> clock cycles, rounded up, at least one cycle
    function automatic int cyc_ceil(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/qdl_elapsed.sv
module qdl_elapsed #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i)
            cnt_d = '0;
        else if (cnt_q == {CW{1'b1}})
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= {CW{1'b1}};
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == {CW{1'b1}} && !clr_i) |=> (cnt_q == {CW{1'b1}}));
endmodule

// File: rtl/qdl_frame_shifter.sv
module qdl_frame_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [23:0]      word_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_o,
    output logic             sdin_o,
    output logic             sync_n_o,
    output logic             last_o
);
    typedef struct packed {
        logic             act;
        logic             low;
        logic [4:0]       bitn;
        logic [DIV_W-1:0] dv;
        logic [DIV_W-1:0] cnt;
        logic [23:0]      sh;
    } shf_t;

    shf_t r_d, r_q;
    logic [DIV_W-1:0] div_m1;

    always_comb begin
        div_m1 = (div_i == '0) ? '0 : div_i - 1'b1;
        r_d    = r_q;
        last_o = 1'b0;
        if (!r_q.act) begin
            if (go_i) begin
                r_d.act  = 1'b1;
                r_d.low  = 1'b0;
                r_d.bitn = '0;
                r_d.dv   = div_m1;
                r_d.cnt  = div_m1;
                r_d.sh   = word_i;
            end
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end else begin
            r_d.cnt = r_q.dv;
            if (!r_q.low) begin
                r_d.low = 1'b1;
            end else begin
                r_d.low = 1'b0;
                r_d.sh  = {r_q.sh[22:0], 1'b0};
                if (r_q.bitn == 5'd23) begin
                    r_d.act = 1'b0;
                    last_o  = 1'b1;
                end else begin
                    r_d.bitn = r_q.bitn + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sclk_o   = !(r_q.act && r_q.low);
    assign sdin_o   = r_q.act && r_q.sh[23];
    assign sync_n_o = !r_q.act;

    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n_o |-> sclk_o);
    p_sdin_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_o && $past(!sclk_o)) |-> $stable(sdin_o));
endmodule

// File: rtl/quad_dac_loader.sv
module quad_dac_loader
    import qdl_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int T_FRAME_NS  = 830,
    parameter int T_SYNCHI_NS = 20,
    parameter int T_LDLY_NS   = 800,
    parameter int T_LDACW_NS  = 20,
    parameter int DIV_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [3:0][15:0] samples_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_o,
    output logic             sdin_o,
    output logic             sync_n_o,
    output logic             ldac_n_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int FRAME_CYC  = cyc_ceil(T_FRAME_NS, CLK_MHZ);
    localparam int SYNCHI_CYC = cyc_ceil(T_SYNCHI_NS, CLK_MHZ);
    localparam int LDLY_CYC   = cyc_ceil(T_LDLY_NS, CLK_MHZ);
    localparam int LDACW_CYC  = cyc_ceil(T_LDACW_NS, CLK_MHZ);
    localparam int MAX_A      = (FRAME_CYC > LDLY_CYC) ? FRAME_CYC : LDLY_CYC;
    localparam int MAX_B      = (SYNCHI_CYC > LDACW_CYC) ? SYNCHI_CYC : LDACW_CYC;
    localparam int MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW         = $clog2(MAX_CYC + 1) + 1;

    localparam logic [CW-1:0] FRAME_M1  = CW'(FRAME_CYC - 1);
    localparam logic [CW-1:0] SYNCHI_M1 = CW'(SYNCHI_CYC - 1);
    localparam logic [CW-1:0] LDLY_M1   = CW'(LDLY_CYC - 1);
    localparam logic [CW-1:0] LDACW_M1  = CW'(LDACW_CYC - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [1:0]       ch;
        logic [3:0][15:0] lat;
        logic             ldac_n;
        logic             busy;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;
    logic go, clr_start, last;
    logic [23:0] word;
    logic [1:0]  nch;
    logic [CW-1:0] start_cnt, end_cnt;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        go        = 1'b0;
        clr_start = 1'b0;
        nch       = s_q.ch + 2'd1;
        word      = make_frame(nch, s_q.lat[nch]);
        case (s_q.st)
            S_IDLE: if (start_i) begin
                go       = 1'b1;
                word     = make_frame(2'd0, samples_i[0]);
                s_d.lat  = samples_i;
                s_d.ch   = 2'd0;
                s_d.busy = 1'b1;
                s_d.st   = S_SEND;
            end
            S_SEND: if (last)
                s_d.st = (s_q.ch == 2'd3) ? S_LDLY : S_GAP;
            S_GAP: if (start_cnt >= FRAME_M1 && end_cnt >= SYNCHI_M1) begin
                go     = 1'b1;
                s_d.ch = nch;
                s_d.st = S_SEND;
            end
            S_LDLY: if (end_cnt >= LDLY_M1) begin
                clr_start  = 1'b1;
                s_d.ldac_n = 1'b0;
                s_d.st     = S_LPULSE;
            end
            S_LPULSE: if (start_cnt >= LDACW_M1) begin
                s_d.ldac_n = 1'b1;
                s_d.done   = 1'b1;
                s_d.busy   = 1'b0;
                s_d.st     = S_IDLE;
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.st     <= S_IDLE;
            s_q.ldac_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    qdl_frame_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .go_i(go), .word_i(word), .div_i(div_i),
        .sclk_o(sclk_o), .sdin_o(sdin_o), .sync_n_o(sync_n_o), .last_o(last)
    );

    qdl_elapsed #(.CW(CW)) u_since_start (
        .clk(clk), .rst_n(rst_n), .clr_i(go | clr_start), .cnt_o(start_cnt)
    );

    qdl_elapsed #(.CW(CW)) u_since_end (
        .clk(clk), .rst_n(rst_n), .clr_i(last), .cnt_o(end_cnt)
    );

    assign ldac_n_o = s_q.ldac_n;
    assign busy_o   = s_q.busy;
    assign done_o   = s_q.done;

    // independent edge observers for the timing properties
    logic          ps_q, pl_q;
    logic [2:0]    frm_q;
    logic [CW-1:0] fall_q, rise_q, lfall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= 1'b1; pl_q <= 1'b1; frm_q <= '0;
            fall_q <= '1; rise_q <= '1; lfall_q <= '1;
        end else begin
            ps_q    <= sync_n_o;
            pl_q    <= ldac_n_o;
            fall_q  <= (ps_q && !sync_n_o) ? CW'(1) : ((fall_q == '1) ? fall_q : fall_q + 1'b1);
            rise_q  <= (!ps_q && sync_n_o) ? CW'(1) : ((rise_q == '1) ? rise_q : rise_q + 1'b1);
            lfall_q <= (pl_q && !ldac_n_o) ? CW'(1) : ((lfall_q == '1) ? lfall_q : lfall_q + 1'b1);
            if (done_o)                frm_q <= '0;
            else if (ps_q && !sync_n_o) frm_q <= frm_q + 3'd1;
        end
    end

    p_frame_space_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_q && !sync_n_o && frm_q != 3'd0) |-> (fall_q >= CW'(FRAME_CYC)));
    p_sync_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_q && !sync_n_o && frm_q != 3'd0) |-> (rise_q >= CW'(SYNCHI_CYC)));
    p_ldac_after_four_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_q && !ldac_n_o) |-> (frm_q == 3'd4 && rise_q >= CW'(LDLY_CYC)));
    p_ldac_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ldac_n_o |-> sync_n_o);
    p_ldac_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pl_q && ldac_n_o) |-> (lfall_q >= CW'(LDACW_CYC)));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && ldac_n_o));
endmodule

// File: tb/sim_quad_dac_loader.sv
`timescale 1ns/1ps
module sim_quad_dac_loader;
    localparam int FRAME_CYC = 83, SYNCHI_CYC = 2, LDLY_CYC = 80, LDACW_CYC = 2;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [3:0][15:0] samples = '0;
    logic [7:0] div = 8'd1;
    logic sclk, sdin, sync_n, ldac_n, busy, done;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    quad_dac_loader u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .samples_i(samples), .div_i(div),
        .sclk_o(sclk), .sdin_o(sdin), .sync_n_o(sync_n), .ldac_n_o(ldac_n),
        .busy_o(busy), .done_o(done)
    );

    // monitor state
    int t = 0, nf = 0, nl = 0, nd = 0, lf_t = 0, lr_t = 0, done_t = 0, lowcnt = 0, serr = 0, deff = 1;
    int fall_t[8], rise_t[8];
    logic [23:0] frm[8];
    logic [23:0] sh = '0;
    logic ps = 1, psc = 1, psd = 0, pl = 1;

    always @(negedge clk) begin
        t++;
        if (ps && !sync_n) begin if (nf < 8) fall_t[nf] = t; sh = '0; end
        if (psc && !sclk) begin sh = {sh[22:0], sdin}; lowcnt = 1; end
        else if (!psc && !sclk) begin lowcnt++; if (sdin !== psd) serr++; end
        if (!psc && sclk && lowcnt != deff) serr++;
        if (sync_n && !sclk) serr++;
        if (!ps && sync_n) begin if (nf < 8) begin frm[nf] = sh; rise_t[nf] = t; end nf++; end
        if (pl && !ldac_n) begin lf_t = t; nl++; end
        if (!pl && ldac_n) lr_t = t;
        if (done) begin nd++; done_t = t; end
        ps = sync_n; psc = sclk; psd = sdin; pl = ldac_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_frame(input int ch, input logic [15:0] v);
        logic [3:0] oh;
        oh = 4'(1 << ch);
        return {4'h1, oh, v};
    endfunction

    // div, ch0, ch1, ch2, ch3
    localparam logic [71:0] VECS [0:3] = '{
        {8'd1, 16'h0000, 16'hFFFF, 16'h8001, 16'h1234},
        {8'd3, 16'hA5A5, 16'h5A5A, 16'h0001, 16'h8000},
        {8'd2, 16'hFFFF, 16'h0000, 16'hC3C3, 16'h7FFE},
        {8'd0, 16'h1357, 16'h9BDF, 16'h2468, 16'hACE0}
    };

    task automatic run_update(input logic [71:0] v, input bit disturb);
        logic [3:0][15:0] orig;
        int d, sp, w;
        d = (v[71:64] == 0) ? 1 : int'(v[71:64]);
        orig[0] = v[63:48]; orig[1] = v[47:32]; orig[2] = v[31:16]; orig[3] = v[15:0];
        @(negedge clk);
        nf = 0; nl = 0; nd = 0; serr = 0; deff = d;
        div = v[71:64]; samples = orig; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R8 busy after start", int'(busy), 1);
        if (disturb) begin
            repeat (100) @(negedge clk);
            samples = ~orig; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (nd == 0 && w < 5000) begin @(negedge clk); w++; end
        chk(w < 5000, "R8 done reached", w, 0);
        chk(busy === 1'b0, "R8 busy cleared", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk(nd == 1, "R8 single done pulse", nd, 1);
        chk(nf == 4, "R2 frame count", nf, 4);
        for (int i = 0; i < 4; i++) begin
            logic [23:0] e;
            e = exp_frame(i, orig[i]);
            checks++;
            if (frm[i] !== e) begin
                fails++;
                $display("FAIL R2 frame %0d actual=%h expected=%h", i, frm[i], e);
            end
            chk(rise_t[i] - fall_t[i] == 48 * d, "R3 sync low width", rise_t[i] - fall_t[i], 48 * d);
        end
        sp = (48 * d + SYNCHI_CYC > FRAME_CYC) ? 48 * d + SYNCHI_CYC : FRAME_CYC;
        for (int i = 0; i < 3; i++) begin
            chk(fall_t[i+1] - fall_t[i] == sp, "R4 frame spacing", fall_t[i+1] - fall_t[i], sp);
            chk(fall_t[i+1] - rise_t[i] >= SYNCHI_CYC, "R5 sync high", fall_t[i+1] - rise_t[i], SYNCHI_CYC);
        end
        chk(serr == 0, "R3 sclk/sdin timing errors", serr, 0);
        chk(nl == 1, "R6 ldac pulse count", nl, 1);
        chk(lf_t - rise_t[3] == LDLY_CYC, "R6 ldac delay", lf_t - rise_t[3], LDLY_CYC);
        chk(lr_t - lf_t == LDACW_CYC, "R7 ldac width", lr_t - lf_t, LDACW_CYC);
        chk(done_t == lr_t, "R8 done with ldac release", done_t, lr_t);
        if (disturb) begin
            repeat (200) @(negedge clk);
            chk(nf == 4 && sync_n === 1'b1, "R9 late start ignored", nf, 4);
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", t, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sync_n === 1'b1, "R1 sync_n reset", int'(sync_n), 1);
        chk(sclk === 1'b1, "R1 sclk reset", int'(sclk), 1);
        chk(ldac_n === 1'b1, "R1 ldac_n reset", int'(ldac_n), 1);
        chk(busy === 1'b0 && done === 1'b0, "R1 busy/done reset", int'({busy, done}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 4; k++) run_update(VECS[k], 1'b0);
        // R9: samples change and start repeats mid-update
        run_update(VECS[1], 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule